// File: doc/BRIEF.md
# Idle Card Clock Controller

This block decides, cycle by cycle, whether the clock for a removable card slot runs at full rate, runs at a reduced rate, or stops. It does this by driving a clock-enable output that downstream clock gating uses. The block watches two activity inputs: a slot access strobe and a card request. When clock saving is switched on and neither input has been active for a set number of consecutive cycles, the enable is lowered. In stop mode the enable stays low. In slow mode it pulses once every sixteen cycles. Any activity brings back the full-rate enable on the next cycle.

The host programs and observes the block through one 32-bit power register. The register sits at byte offset 20h of a simple register bus that uses a read strobe and a write strobe. The register holds four live bits:

- a saving enable;
- a stop/slow selector;
- a read-only flag that shows the clock is currently reduced;
- a sticky access flag, which is cleared by reading the register.

All other bits read as zero. The whole block is cleared only by its global reset.

Top module: `card_clk_pm`

## Requirements
- R1: After global reset (`rst_n` low) every register bit reads 0 and `card_clk_en` is 1.
- R2: Reads and writes act only when `reg_addr` equals 20h. A write to any other address leaves the register unchanged. A read of any other address returns 0. A read of 20h returns the register in the same cycle.
- R3: Bits 31:26, 23:17 and 15:1 always read 0, whatever was written to them.
- R4: While bit 16 (saving enable) is 0, `card_clk_en` stays 1 regardless of bit 0 and of activity.
- R5: With bit 16 set, a reduction begins when the idle count has reached 64 (the default `IDLE_CYCLES`) and the cycle is still idle. The idle count is the number of consecutive cycles with both `card_access` and `card_req` low. From the following edge `card_clk_en` leaves its constant-1 state.
- R6: A cycle with `card_access` or `card_req` high makes `card_clk_en` 1 in the next cycle. It also restarts the idle count.
- R7: With bit 0 = 0 (stop), `card_clk_en` stays 0 for the whole time the clock is reduced.
- R8: With bit 0 = 1 (slow), `card_clk_en` is 1 in the 16th cycle of the reduction and then in every 16th cycle after that. It is 0 in all other reduced cycles.
- R9: Bit 24 reads 1 exactly while the clock is reduced (stopped or slowed) and reads 0 otherwise.
- R10: Bit 25 becomes 1 after any cycle with `card_access` high. It returns to 0 after a read of 20h.
- R11: If `card_access` is high in the same cycle as a read of 20h, bit 25 is 1 afterwards.
- R12: A write that changes bit 0 ends any reduction at the next edge. It also restarts the idle count.
- R13: A write to 20h is visible in the register and in the clock behaviour from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the undivided card clock source |
| rst_n | input | 1 | Global reset, active low, synchronous |
| reg_addr | input | 8 | Register bus byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the access flag) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, zero when not reading the register |
| card_access | input | 1 | Slot access event, one pulse per access |
| card_req | input | 1 | Card request for clock, level |
| card_clk_en | output | 1 | Card clock enable: 1 = clock edge passes |

## Verification
Two collisions matter here. The first is a slot access in the same cycle as a host read, which must leave the access flag set. The bench drives `card_access` during a read strobe and expects the returned word to show the old flag. The next read must then show 1.

The second collision is a mode-select write that lands while the clock is reduced. The bench issues this write during an active stop and checks two things: the enable returns to 1 on the next cycle, and a fresh idle period of the full length passes before the slow pattern starts.

A behavioural reference model predicts the enable on every cycle. It flags any cycle that is off by one at the idle threshold (63, 64 and 65 idle cycles are all driven) or in the 16-cycle pulse spacing.

// File: rtl/card_pm_pkg.sv
package card_pm_pkg;

   localparam int PM_DATA_W  = 32;
   localparam int PM_BIT_SEL = 0;
   localparam int PM_BIT_EN  = 16;
   localparam int PM_BIT_RED = 24;
   localparam int PM_BIT_ACC = 25;

   typedef enum logic {
      IDLE_STOP = 1'b0,
      IDLE_SLOW = 1'b1
   } idle_mode_e;

   typedef struct packed {
      logic       save_en;
      idle_mode_e mode;
   } pm_ctrl_t;

endpackage

// File: rtl/pm_regfile.sv
module pm_regfile
   import card_pm_pkg::*;
#(
   parameter int              ADDR_W = 8,
   parameter logic [ADDR_W-1:0] OFFSET = 'h20,
   parameter int              DATA_W = PM_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              wr_en_bit,
   input  logic              wr_sel_bit,
   input  logic              card_access,
   input  logic              reduced,
   output pm_ctrl_t          ctrl,
   output logic              save_en_next,
   output logic              mode_change,
   output logic              acc_flag,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rdata
);

   localparam int MAX_BIT = PM_BIT_ACC;

   if (MAX_BIT >= DATA_W) begin : g_bad_width
      $error("pm_regfile: DATA_W too small for field positions");
   end

   logic wr_hit;
   logic [DATA_W-1:0] img;

   assign wr_hit = wr && (addr == OFFSET);
   assign rd_hit = rd && (addr == OFFSET);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         acc_flag <= 1'b0;
      end else begin
         if (wr_hit) begin
            ctrl.save_en <= wr_en_bit;
            ctrl.mode    <= idle_mode_e'(wr_sel_bit);
         end
         if (card_access)
            acc_flag <= 1'b1;
         else if (rd_hit)
            acc_flag <= 1'b0;
      end
   end

   assign save_en_next = wr_hit ? wr_en_bit : ctrl.save_en;
   assign mode_change  = wr_hit && (wr_sel_bit != ctrl.mode);

   for (genvar i = 0; i < DATA_W; i++) begin : g_img
      if (i == PM_BIT_SEL) begin : g_sel
         assign img[i] = ctrl.mode;
      end else if (i == PM_BIT_EN) begin : g_en
         assign img[i] = ctrl.save_en;
      end else if (i == PM_BIT_RED) begin : g_red
         assign img[i] = reduced;
      end else if (i == PM_BIT_ACC) begin : g_acc
         assign img[i] = acc_flag;
      end else begin : g_rsvd
         assign img[i] = 1'b0;
      end
   end

   assign rdata = rd_hit ? img : '0;

endmodule

// File: rtl/idle_detect.sv
module idle_detect #(
   parameter int IDLE_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic activity,
   input  logic restart,
   input  logic save_en_next,
   output logic reduced
);

   localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_CYCLES);

   if (IDLE_CYCLES < 1) begin : g_bad_idle
      $error("idle_detect: IDLE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] idle_cnt;
   logic             at_limit;

   assign at_limit = (idle_cnt == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         reduced  <= 1'b0;
      end else begin
         if (activity || restart)
            idle_cnt <= '0;
         else if (!at_limit)
            idle_cnt <= idle_cnt + 1'b1;
         reduced <= save_en_next && at_limit && !activity && !restart;
      end
   end

endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen
   import card_pm_pkg::*;
#(
   parameter int DIV_RATIO = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reduced,
   input  idle_mode_e mode,
   output logic       clk_en
);

   if (DIV_RATIO < 1) begin : g_bad_div
      $error("clk_en_gen: DIV_RATIO must be at least 1");
   end

   if (DIV_RATIO == 1) begin : g_nodiv
      assign clk_en = !reduced || (mode == IDLE_SLOW);
   end else begin : g_div
      localparam int DW = $clog2(DIV_RATIO);
      localparam logic [DW-1:0] LAST = DW'(DIV_RATIO - 1);
      logic [DW-1:0] phase;

      always_ff @(posedge clk) begin
         if (!rst_n || !reduced)
            phase <= '0;
         else if (phase == LAST)
            phase <= '0;
         else
            phase <= phase + 1'b1;
      end

      assign clk_en = !reduced || ((mode == IDLE_SLOW) && (phase == LAST));
   end

endmodule

// File: rtl/card_clk_pm.sv
module card_clk_pm
   import card_pm_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          PM_OFFSET   = 'h20,
   parameter int          IDLE_CYCLES = 64,
   parameter int          DIV_RATIO   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              card_access,
   input  logic              card_req,
   output logic              card_clk_en
);

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(PM_OFFSET);

   if (PM_OFFSET % 4 != 0) begin : g_bad_align
      $error("card_clk_pm: PM_OFFSET must be word aligned");
   end
   if (PM_OFFSET >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("card_clk_pm: PM_OFFSET outside address range");
   end

   pm_ctrl_t ctrl;
   logic     save_en_next;
   logic     mode_change;
   logic     acc_flag;
   logic     rd_hit;
   logic     reduced_q;
   logic     activity;

   assign activity = card_access || card_req;

   pm_regfile #(
      .ADDR_W (ADDR_W),
      .OFFSET (OFS),
      .DATA_W (PM_DATA_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr         (reg_addr),
      .wr           (reg_wr),
      .rd           (reg_rd),
      .wr_en_bit    (reg_wdata[PM_BIT_EN]),
      .wr_sel_bit   (reg_wdata[PM_BIT_SEL]),
      .card_access  (card_access),
      .reduced      (reduced_q),
      .ctrl         (ctrl),
      .save_en_next (save_en_next),
      .mode_change  (mode_change),
      .acc_flag     (acc_flag),
      .rd_hit       (rd_hit),
      .rdata        (reg_rdata)
   );

   idle_detect #(
      .IDLE_CYCLES (IDLE_CYCLES)
   ) u_idle (
      .clk          (clk),
      .rst_n        (rst_n),
      .activity     (activity),
      .restart      (mode_change),
      .save_en_next (save_en_next),
      .reduced      (reduced_q)
   );

   clk_en_gen #(
      .DIV_RATIO (DIV_RATIO)
   ) u_cken (
      .clk     (clk),
      .rst_n   (rst_n),
      .reduced (reduced_q),
      .mode    (ctrl.mode),
      .clk_en  (card_clk_en)
   );

endmodule

// File: rtl/card_clk_pm_chk.sv
module card_clk_pm_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        card_access,
   input logic        card_req,
   input logic        rd_hit,
   input logic [31:0] reg_rdata,
   input logic        card_clk_en,
   input logic        save_en,
   input logic        mode_slow,
   input logic        reduced,
   input logic        acc_flag
);

   localparam logic [31:0] RSVD_MASK = 32'hFCFE_FFFE;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & RSVD_MASK) == 32'h0);                                  // R3
   AST_DISABLED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (!save_en && !reduced) |-> card_clk_en);                            // R4
   AST_WAKE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (card_access || card_req) |=> card_clk_en);                         // R6
   AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (reduced && !mode_slow) |-> !card_clk_en);                          // R7
   AST_SLOW_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (reduced && mode_slow && card_clk_en && !card_access && !card_req) |=> !card_clk_en); // R8
   AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      card_access |=> acc_flag);                                          // R11
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !card_access) |=> !acc_flag);                            // R10

endmodule

bind card_clk_pm card_clk_pm_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .card_access (card_access),
   .card_req    (card_req),
   .rd_hit      (rd_hit),
   .reg_rdata   (reg_rdata),
   .card_clk_en (card_clk_en),
   .save_en     (ctrl.save_en),
   .mode_slow   (ctrl.mode),
   .reduced     (reduced_q),
   .acc_flag    (acc_flag)
);

// File: tb/tb_card_clk_pm.sv
`timescale 1ns/1ps
module tb_card_clk_pm;

   localparam int IDLE = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        card_access = 1'b0;
   logic        card_req = 1'b0;
   logic        card_clk_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   bit m_en, m_sel, m_acc, m_red, m_rose;
   int m_cnt, m_div;

   always #2.5 clk = ~clk;

   card_clk_pm #(.IDLE_CYCLES(IDLE)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .card_access(card_access), .card_req(card_req), .card_clk_en(card_clk_en)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit exp_clk_en();
      if (!m_red) return 1'b1;
      if (!m_sel) return 1'b0;
      return (m_div == 15);
   endfunction

   function automatic logic [31:0] exp_word();
      logic [31:0] w = '0;
      w[0] = m_sel; w[16] = m_en; w[24] = m_red; w[25] = m_acc;
      return w;
   endfunction

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_sel = 0; m_acc = 0; m_red = 0; m_rose = 0; m_cnt = 0; m_div = 0;
      end else begin
         bit act, whit, rhit, n_en, n_sel, chg, n_red;
         act  = card_access | card_req;
         whit = reg_wr && reg_addr == 8'h20;
         rhit = reg_rd && reg_addr == 8'h20;
         n_en  = whit ? reg_wdata[16] : m_en;
         n_sel = whit ? reg_wdata[0]  : m_sel;
         chg   = whit && (reg_wdata[0] != m_sel);
         n_red = n_en && !act && !chg && (m_cnt == IDLE);
         m_div = m_red ? (m_div + 1) % 16 : 0;
         if (act || chg) m_cnt = 0;
         else if (m_cnt < IDLE) m_cnt++;
         if (card_access) m_acc = 1;
         else if (rhit) m_acc = 0;
         m_rose = n_red && !m_red;
         m_red = n_red; m_en = n_en; m_sel = n_sel;
      end
   end

   // per-cycle comparison of the enable output
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string tag;
         if (!m_en && !m_red) tag = "R4";
         else if (m_rose) tag = "R5";
         else if (!m_red) tag = "R6";
         else if (m_sel) tag = "R8";
         else tag = "R7";
         check(tag, {31'b0, card_clk_en}, {31'b0, exp_clk_en()});
      end
   end

   task automatic wr_reg(logic [7:0] a, logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_reg(string tag, logic [7:0] a, bit with_access);
      reg_addr = a; reg_rd = 1; card_access = with_access;
      #1;
      check(tag, reg_rdata, (a == 8'h20) ? exp_word() : 32'h0);
      @(negedge clk);
      reg_rd = 0; card_access = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_access();
      card_access = 1; @(negedge clk); card_access = 0;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      check("R1", {31'b0, card_clk_en}, 32'h1);
      rd_reg("R1", 8'h20, 0);
      // R2: writes elsewhere ignored, reads elsewhere zero
      wr_reg(8'h24, 32'hFFFF_FFFF);
      rd_reg("R2", 8'h20, 0);
      rd_reg("R2", 8'h24, 0);
      // R3 / R13: all ones written, only live bits stick, seen next cycle
      wr_reg(8'h20, 32'hFFFF_FFFF);
      rd_reg("R13", 8'h20, 0);
      rd_reg("R3", 8'h20, 0);
      // slow mode idle period (R5, R8), status bit (R9)
      idle(IDLE + 40);
      rd_reg("R9", 8'h20, 0);
      idle(30);
      card_req = 1; @(negedge clk); card_req = 0;   // R6
      idle(3);
      rd_reg("R9", 8'h20, 0);
      // stop mode (R7) then mode change while stopped (R12)
      wr_reg(8'h20, 32'h0001_0000);
      idle(IDLE + 10);
      rd_reg("R9", 8'h20, 0);
      wr_reg(8'h20, 32'h0001_0001);
      rd_reg("R12", 8'h20, 0);
      idle(IDLE + 40);
      // access flag (R10)
      pulse_access();
      rd_reg("R10", 8'h20, 0);
      rd_reg("R10", 8'h20, 0);
      // collision of access and read (R11)
      rd_reg("R11", 8'h20, 1);
      rd_reg("R11", 8'h20, 0);
      // idle windows around threshold (R5)
      for (int k = IDLE - 1; k <= IDLE + 2; k++) begin
         pulse_access();
         idle(k);
      end
      idle(20);
      // disabled: no reduction whatever the select (R4)
      wr_reg(8'h20, 32'h0000_0001);
      idle(IDLE + 30);
      wr_reg(8'h20, 32'h0000_0000);
      idle(IDLE + 30);
      rd_reg("R4", 8'h20, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule